// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads translation descriptors from memory through a plain read port. A request carries the virtual address and the current table base. The walker reads the first-level entry. If that entry maps a 1 MB section, the walk stops there. If it points to a second-level table, the walker makes one more read, which yields a 64 KB or a 4 KB page. When no valid mapping exists, the walker reports a fault instead of an address.

The walker handles one translation at a time. The requester offers a request with a valid/ready handshake and then waits for a one-cycle `done` or `fault` pulse. Descriptor reads use a valid/ready request channel and a response strobe. There is no response back-pressure, so a response may come any number of cycles after its read is accepted.

Top module: `addr_walker`

## Requirements
- R1: While reset is held and right after it, `req_ready` is 1 and `done`, `fault` and `mem_rd_valid` are 0.
- R2: The first read goes to the address made of table base bits [31:14], then virtual address bits [31:20], then two zero bits.
- R3: A first-level descriptor whose bits [1:0] are 2'b10 is a section. The walk ends after that single read, and `pa` is descriptor bits [31:20] followed by virtual address bits [19:0].
- R4: A first-level descriptor whose bits [1:0] are 2'b01 points to a second-level table. The second read goes to descriptor bits [31:10], then virtual address bits [19:12], then two zero bits.
- R5: A second-level descriptor whose bits [1:0] are 2'b01 is a 64 KB page: `pa` is descriptor bits [31:16] followed by virtual address bits [15:0].
- R6: A second-level descriptor whose bits [1:0] are 2'b10 is a 4 KB page: `pa` is descriptor bits [31:12] followed by virtual address bits [11:0].
- R7: A first-level descriptor whose bits [1:0] are 2'b00 or 2'b11 ends the walk with `fault` and `pa` = 0, and no second read is issued.
- R8: A second-level descriptor whose bits [1:0] are 2'b00 or 2'b11 ends the walk with `fault` and `pa` = 0.
- R9: `req_ready` goes low in the cycle after a request is accepted. It stays low through the single cycle in which `done` or `fault` is high, and goes high again in the next cycle. `done` and `fault` are never high together, and no read is issued while the walker is idle.
- R10: Once `mem_rd_valid` is raised, it and `mem_rd_addr` hold steady until `mem_rd_ready` is seen.
- R11: The virtual address and table base are sampled when the request is accepted; later changes on those inputs have no effect. A response strobe with no read outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| tbl_base | input | 32 | Table base register value; bits [31:14] used |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Descriptor word address (byte address, bits [1:0] zero) |
| mem_rsp_valid | input | 1 | Descriptor data strobe |
| mem_rsp_data | input | 32 | Descriptor word |
| done | output | 1 | One-cycle pulse: translation finished, `pa` valid |
| fault | output | 1 | One-cycle pulse: no valid mapping |
| pa | output | 32 | Physical address result |

## Verification
The completion pulse and the arrival of the next request can fall in the same cycle. The bench raises `req_valid` with fresh values while the final descriptor is being returned, so the request is pending during the `done` cycle. It then checks that `req_ready` is low in that cycle, that the request is taken only in the cycle after, and that the second walk uses the fresh values. In a related case, the address inputs change in the cycle right after acceptance. The read address and result must still follow the sampled values.

// File: rtl/walk_pkg.sv
package walk_pkg;
  localparam int AW        = 32;
  localparam int BASE_LSB  = 14;
  localparam int L1_LSB    = 20;
  localparam int L2_LSB    = 12;
  localparam int L2_W      = L1_LSB - L2_LSB;
  localparam int TBL_LSB   = L2_W + 2;
  localparam int LRG_LSB   = 16;

  localparam logic [1:0] TY_NONE = 2'b00;
  localparam logic [1:0] TY_LINK = 2'b01;
  localparam logic [1:0] TY_LEAF = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD1, ST_WT1, ST_RD2, ST_WT2, ST_FIN
  } wstate_t;

  function automatic logic [AW-1:0] lvl1_addr(input logic [AW-1:0] base, input logic [AW-1:0] va);
    return {base[AW-1:BASE_LSB], va[AW-1:L1_LSB], 2'b00};
  endfunction

  function automatic logic [AW-1:0] lvl2_addr(input logic [AW-1:0] d1, input logic [AW-1:0] va);
    return {d1[AW-1:TBL_LSB], va[L1_LSB-1:L2_LSB], 2'b00};
  endfunction

  function automatic logic [AW-1:0] join_at(input logic [AW-1:0] d, input logic [AW-1:0] va, input int lsb);
    logic [AW-1:0] m;
    m = {AW{1'b1}} << lsb;
    return (d & m) | (va & ~m);
  endfunction
endpackage

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       mem_rd_ready,
  input  logic       mem_rsp_valid,
  input  logic [1:0] rsp_ty,
  output logic       req_ready,
  output logic       mem_rd_valid,
  output logic       sel_l2,
  output logic       take_req,
  output logic       ev_sect,
  output logic       ev_coarse,
  output logic       ev_page,
  output logic       ev_flt,
  output logic       done,
  output logic       fault
);
  wstate_t state_q, state_d;
  logic    ok_q;
  logic    rsp1, rsp2;

  always_comb begin
    take_req  = (state_q == ST_IDLE) && req_valid;
    rsp1      = (state_q == ST_WT1) && mem_rsp_valid;
    rsp2      = (state_q == ST_WT2) && mem_rsp_valid;
    ev_sect   = rsp1 && (rsp_ty == TY_LEAF);
    ev_coarse = rsp1 && (rsp_ty == TY_LINK);
    ev_page   = rsp2 && ((rsp_ty == TY_LINK) || (rsp_ty == TY_LEAF));
    ev_flt    = (rsp1 && !ev_sect && !ev_coarse) || (rsp2 && !ev_page);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (take_req) state_d = ST_RD1;
      ST_RD1:  if (mem_rd_ready) state_d = ST_WT1;
      ST_WT1:  if (ev_coarse) state_d = ST_RD2;
               else if (rsp1) state_d = ST_FIN;
      ST_RD2:  if (mem_rd_ready) state_d = ST_WT2;
      ST_WT2:  if (rsp2) state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ok_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ev_sect || ev_page || ev_flt) ok_q <= !ev_flt;
    end
  end

  always_comb begin
    req_ready    = (state_q == ST_IDLE);
    mem_rd_valid = (state_q == ST_RD1) || (state_q == ST_RD2);
    sel_l2       = (state_q == ST_RD2) || (state_q == ST_WT2);
    done         = (state_q == ST_FIN) && ok_q;
    fault        = (state_q == ST_FIN) && !ok_q;
  end
endmodule

// File: rtl/walk_dpath.sv
module walk_dpath
  import walk_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_req,
  input  logic [AW-1:0] req_vaddr,
  input  logic [AW-1:0] tbl_base,
  input  logic          sel_l2,
  input  logic          ev_sect,
  input  logic          ev_coarse,
  input  logic          ev_page,
  input  logic          ev_flt,
  input  logic [AW-1:0] rsp_data,
  output logic [AW-1:0] mem_rd_addr,
  output logic [AW-1:0] pa
);
  logic [AW-1:0] va_q, base_q, d1_q, pa_q;
  logic [AW-1:0] page_pa;

  always_comb begin
    page_pa     = (rsp_data[1:0] == TY_LINK) ? join_at(rsp_data, va_q, LRG_LSB)
                                             : join_at(rsp_data, va_q, L2_LSB);
    mem_rd_addr = sel_l2 ? lvl2_addr(d1_q, va_q) : lvl1_addr(base_q, va_q);
    pa          = pa_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_q   <= '0;
      base_q <= '0;
      d1_q   <= '0;
      pa_q   <= '0;
    end else begin
      if (take_req) begin
        va_q   <= req_vaddr;
        base_q <= tbl_base;
      end
      if (ev_coarse) d1_q <= rsp_data;
      if (ev_sect)      pa_q <= join_at(rsp_data, va_q, L1_LSB);
      else if (ev_page) pa_q <= page_pa;
      else if (ev_flt)  pa_q <= '0;
    end
  end
endmodule

// File: rtl/addr_walker.sv
module addr_walker
  import walk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic [31:0] tbl_base,
  output logic        mem_rd_valid,
  input  logic        mem_rd_ready,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic        done,
  output logic        fault,
  output logic [31:0] pa
);
  logic sel_l2, take_req;
  logic ev_sect, ev_coarse, ev_page, ev_flt;

  walk_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .mem_rd_ready (mem_rd_ready),
    .mem_rsp_valid(mem_rsp_valid),
    .rsp_ty       (mem_rsp_data[1:0]),
    .req_ready    (req_ready),
    .mem_rd_valid (mem_rd_valid),
    .sel_l2       (sel_l2),
    .take_req     (take_req),
    .ev_sect      (ev_sect),
    .ev_coarse    (ev_coarse),
    .ev_page      (ev_page),
    .ev_flt       (ev_flt),
    .done         (done),
    .fault        (fault)
  );

  walk_dpath u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_req   (take_req),
    .req_vaddr  (req_vaddr),
    .tbl_base   (tbl_base),
    .sel_l2     (sel_l2),
    .ev_sect    (ev_sect),
    .ev_coarse  (ev_coarse),
    .ev_page    (ev_page),
    .ev_flt     (ev_flt),
    .rsp_data   (mem_rsp_data),
    .mem_rd_addr(mem_rd_addr),
    .pa         (pa)
  );
endmodule

// File: rtl/walk_chk.sv
module walk_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        mem_rd_valid,
  input logic        mem_rd_ready,
  input logic [31:0] mem_rd_addr,
  input logic        done,
  input logic        fault,
  input logic [31:0] pa,
  input logic        ev_sect,
  input logic        ev_page,
  input logic        ev_flt
);
  AST_PULSE_EXCL:  assert property (@(posedge clk) disable iff (!rst_n) !(done && fault)); // R9
  AST_PULSE_ONE:   assert property (@(posedge clk) disable iff (!rst_n) (done || fault) |=> !(done || fault)); // R9
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> !req_ready); // R9
  AST_END_BUSY:    assert property (@(posedge clk) disable iff (!rst_n) (done || fault) |-> !req_ready); // R9
  AST_RELEASE:     assert property (@(posedge clk) disable iff (!rst_n) (done || fault) |=> req_ready); // R9
  AST_IDLE_QUIET:  assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> !mem_rd_valid); // R9
  AST_RD_HOLD:     assert property (@(posedge clk) disable iff (!rst_n)
                     (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R10
  AST_SECT_EARLY:  assert property (@(posedge clk) disable iff (!rst_n) ev_sect |=> (done && !mem_rd_valid)); // R3
  AST_PAGE_DONE:   assert property (@(posedge clk) disable iff (!rst_n) ev_page |=> done); // R5
  AST_FLT_OUT:     assert property (@(posedge clk) disable iff (!rst_n) ev_flt |=> (fault && pa == 32'd0)); // R7
endmodule

bind addr_walker walk_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .mem_rd_valid(mem_rd_valid),
  .mem_rd_ready(mem_rd_ready),
  .mem_rd_addr (mem_rd_addr),
  .done        (done),
  .fault       (fault),
  .pa          (pa),
  .ev_sect     (ev_sect),
  .ev_page     (ev_page),
  .ev_flt      (ev_flt)
);

// File: tb/test_addr_walker.sv
`timescale 1ns/1ps
module test_addr_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [31:0] tbl_base = '0;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done, fault;
  logic [31:0] pa;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  addr_walker i_addr_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .tbl_base(tbl_base), .mem_rd_valid(mem_rd_valid),
    .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .fault(fault), .pa(pa)
  );

  // rows: vaddr, table base, level-1 descriptor, level-2 descriptor
  localparam logic [31:0] VEC [8][4] = '{
    '{32'h1234_5678, 32'h8000_4000, 32'hABC0_0C12, 32'h0000_0000},
    '{32'hCAFE_BABE, 32'h0001_C000, 32'h4567_8801, 32'h9876_0005},
    '{32'h0000_1FFF, 32'hFFFF_C000, 32'h0000_0401, 32'h1357_9A02},
    '{32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFC, 32'h0000_0000},
    '{32'h0010_0000, 32'h1234_7FFF, 32'h0000_0003, 32'h0000_0000},
    '{32'h7654_3210, 32'h0000_8000, 32'hFEDC_B801, 32'h0000_FFFC},
    '{32'h0FF0_0123, 32'h4000_0000, 32'h0000_0001, 32'hFFFF_FFFF},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFF0_0002, 32'h0000_0000}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic serve(input logic [31:0] exp_addr, input logic [31:0] data,
                       input int rdy_dly, input int lat, input string req,
                       input bit arm, input logic [31:0] nva, input logic [31:0] nbase);
    int n = 0;
    while (!mem_rd_valid && n < 20) begin @(negedge clk); n++; end
    chk(mem_rd_valid, req, "read issued", {31'd0, mem_rd_valid}, 32'd1);
    chk(mem_rd_addr == exp_addr, req, "read address", mem_rd_addr, exp_addr);
    for (int k = 0; k < rdy_dly; k++) begin
      @(negedge clk);
      chk(mem_rd_valid && mem_rd_addr == exp_addr, "R10", "held read", mem_rd_addr, exp_addr);
    end
    mem_rd_ready = 1'b1;
    @(negedge clk);
    mem_rd_ready = 1'b0;
    for (int k = 0; k < lat; k++) @(negedge clk);
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = data;
    if (arm) begin
      req_valid = 1'b1;
      req_vaddr = nva;
      tbl_base  = nbase;
    end
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 32'hDEAD_BEEF;
  endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] base,
                      input logic [31:0] d1, input logic [31:0] d2,
                      input int rd, input int lat, input bit arm,
                      input logic [31:0] nva, input logic [31:0] nbase);
    logic [31:0] l1a, l2a, epa;
    bit two, eok;
    string rq;
    l1a = (base & 32'hFFFF_C000) | ((va >> 20) << 2);
    l2a = (d1 & 32'hFFFF_FC00) | (((va >> 12) & 32'hFF) << 2);
    two = (d1[1:0] == 2'b01);
    epa = 32'd0;
    eok = 1'b0;
    if (d1[1:0] == 2'b10) begin
      eok = 1; epa = (d1 & 32'hFFF0_0000) | (va & 32'h000F_FFFF); rq = "R3";
    end else if (!two) begin
      rq = "R7";
    end else if (d2[1:0] == 2'b01) begin
      eok = 1; epa = (d2 & 32'hFFFF_0000) | (va & 32'h0000_FFFF); rq = "R5";
    end else if (d2[1:0] == 2'b10) begin
      eok = 1; epa = (d2 & 32'hFFFF_F000) | (va & 32'h0000_0FFF); rq = "R6";
    end else begin
      rq = "R8";
    end
    req_vaddr = va;
    tbl_base  = base;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_vaddr = ~va;   // R11: later input changes must be ignored
    tbl_base  = ~base;
    chk(!req_ready, "R9", "busy after accept", {31'd0, req_ready}, 32'd0);
    serve(l1a, d1, rd, lat, "R2", arm && !two, nva, nbase);
    if (two) serve(l2a, d2, rd, lat, "R4", arm, nva, nbase);
    chk(done == eok, rq, "done", {31'd0, done}, {31'd0, eok});
    chk(fault == !eok, rq, "fault", {31'd0, fault}, {31'd0, !eok});
    chk(pa == epa, rq, "pa", pa, epa);
    chk(!req_ready && !mem_rd_valid, "R9", "busy in end cycle, no extra read",
        {30'd0, req_ready, mem_rd_valid}, 32'd0);
    @(negedge clk);
    chk(!done && !fault && req_ready, "R9", "pulse single, ready back",
        {29'd0, done, fault, req_ready}, 32'd1);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state while held
    chk(req_ready && !done && !fault && !mem_rd_valid, "R1", "reset outputs",
        {28'd0, req_ready, done, fault, mem_rd_valid}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !done && !fault && !mem_rd_valid, "R1", "after reset",
        {28'd0, req_ready, done, fault, mem_rd_valid}, 32'h8);

    // R11: stray response strobe while idle is ignored
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = 32'h1230_0002;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    @(negedge clk);
    chk(!done && !fault && req_ready, "R11", "stray response ignored",
        {29'd0, done, fault, req_ready}, 32'd1);

    for (int i = 0; i < 8; i++)
      walk(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], i % 3, i % 4, 1'b0, 32'd0, 32'd0);

    // R9: next request pending during the done cycle of a small-page walk
    walk(32'h2468_ACE0, 32'h0000_4000, 32'h7770_0401, 32'h5550_0002, 1, 0,
         1'b1, 32'h3570_0000, 32'h0000_C000);
    chk(req_valid && req_ready, "R9", "pending request now acceptable",
        {30'd0, req_valid, req_ready}, 32'd3);
    walk(32'h3570_0000, 32'h0000_C000, 32'h0110_0C02, 32'd0, 0, 1, 1'b0, 32'd0, 32'd0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule